// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block watches the write traffic of a flash controller's host bus and handles the small set of commands that software may write into the two boot-buffer address windows. There are three such commands. One requests a warm reset of the controller. One stores the identification bytes into the first three boot-RAM words. The third is a two-write load sequence that fetches one page from the array into data buffer 0. Writes to any other address are left to the register file and are ignored here.

A load is a two-step sequence. The first write arms the sequencer. The second write to a boot window is taken as the confirmation value and is never decoded as a command. A confirmation value of zero issues a page-load request to the array side. The sector number of that request is built from the block and page address registers. The request is held until the array side acknowledges it. On the acknowledge, the block returns the page address advanced by four, wrapped to eight bits, so that the register file can write it back. Any other confirmation value drops the sequence. Boot-window writes are ignored while a load request is outstanding or while the identification words are still being written.

Top module: `bootcmd_seq`

## Requirements
- R1: A write is decoded only if its word address is in 0x0000..0x01FF or 0x8000..0x800F. A write elsewhere changes no output and no state, including an armed sequence.
- R2: An accepted, unarmed write of 0x00F0 drives `warm_rst` high for exactly one cycle, starting in the cycle after the write.
- R3: An accepted, unarmed write of 0x00E0 sets `armed` from the next cycle. The next accepted write clears `armed` and is consumed as the confirmation value, so a 0x00F0 or 0x0090 value written then has no command effect.
- R4: A confirmation value of 0x0000 raises `ld_req` in the next cycle. Any other confirmation value leaves `ld_req` low.
- R5: `ld_sector` = pg[1:0] + ((pg[7:2] + F·64) << SUBPG_SH). Here pg is the page register, and F is `blk_num`, ORed with DENS_MASK when `blk_hi` is 1. The defaults are SUBPG_SH=2 and DENS_MASK=0x400.
- R6: `ld_req` and `ld_sector` stay unchanged until `ld_ack` is sampled high. `ld_req` falls in the next cycle. A boot-window write sampled while `ld_req` is high is ignored, even in the acknowledge cycle.
- R7: In the cycle after the acknowledge, `pg_upd` is high for one cycle. `pg_upd_val` then holds (pg[7:0] captured at the request + 4) mod 256.
- R8: An accepted, unarmed write of 0x0090 produces three boot-RAM writes on consecutive cycles, starting the next cycle. Index 0 carries `mfr_id`, index 1 carries `dev_id` and index 2 carries `wp_low`, each zero-extended to 16 bits. Boot-window writes sampled during these three cycles are ignored.
- R9: Any other accepted, unarmed value sets `unk_cmd`. The flag stays set until `rst_n` is low, and no other output changes.
- R10: After reset, `armed`, `ld_req`, `pg_upd`, `bram_we`, `warm_rst`, `unk_cmd` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 16 | Host word address |
| bus_wdata | input | 16 | Host write data |
| blk_num | input | BLK_W | Block field of the block address register |
| blk_hi | input | 1 | Upper-die select bit of the block register |
| pg_reg | input | 8 | Page address register, low byte |
| mfr_id | input | 8 | Manufacturer identification byte |
| dev_id | input | 8 | Device identification byte |
| wp_low | input | 8 | Low byte of write-protection status |
| ld_req | output | 1 | Page-load request to data buffer 0 |
| ld_sector | output | SEC_W | Starting sector of the load |
| ld_ack | input | 1 | Array side accepts the load |
| pg_upd | output | 1 | Page register write-back strobe |
| pg_upd_val | output | 8 | Advanced page address |
| bram_we | output | 1 | Boot RAM write enable |
| bram_widx | output | 2 | Boot RAM word index |
| bram_wdata | output | 16 | Boot RAM write data |
| warm_rst | output | 1 | Warm reset pulse |
| armed | output | 1 | Load sequence awaiting confirmation |
| unk_cmd | output | 1 | Sticky unknown-command flag |
| busy | output | 1 | Boot-window writes currently ignored |

## Verification
Two events can coincide in one cycle: the array side acknowledges an outstanding load, and a new boot-window write arrives. The bench drives `ld_ack` and a write of 0x00E0 on the same clock edge. It expects the load to complete, with `ld_req` falling and the page update appearing. It also expects the write to be dropped, so `armed` stays low. A second case places a write inside the three-cycle identification burst. That write must likewise be dropped, and the burst must continue undisturbed.

// File: rtl/bootcmd_pkg.sv
// Shared constants for the boot-window command sequencer.
// Assumes 16-bit host data; command values are compared on all 16 bits.
package bootcmd_pkg;
    typedef enum logic [15:0] {
        BC_IDENT = 16'h0090,
        BC_LOAD  = 16'h00E0,
        BC_RESET = 16'h00F0
    } boot_cmd_e;

    localparam logic [15:0] LOAD_CONFIRM = 16'h0000;
    localparam int          ID_WORDS     = 3;
    localparam int          ID_IDX_W     = 2;
endpackage

// File: rtl/boot_win_dec.sv
// Boot window decoder: flags a host address that falls inside either
// boot-buffer window. Purely combinational; assumes word addressing.
module boot_win_dec #(
    parameter logic [15:0] LO_BASE = 16'h0000,
    parameter logic [15:0] LO_LAST = 16'h01FF,
    parameter logic [15:0] HI_BASE = 16'h8000,
    parameter logic [15:0] HI_LAST = 16'h800F
) (
    input  logic [15:0] addr,
    output logic        in_win
);
    logic in_lo;
    logic in_hi;

    // Range compare against both windows.
    always_comb begin
        in_lo  = (addr >= LO_BASE) && (addr <= LO_LAST);
        in_hi  = (addr >= HI_BASE) && (addr <= HI_LAST);
        in_win = in_lo || in_hi;
    end
endmodule

// File: rtl/boot_sector_calc.sv
// Sector calculator: forms the first sector of a page from the block
// and page registers. Assumes a 64-page block. SUBPG_SH is log2 of
// the number of sectors per page.
module boot_sector_calc #(
    parameter int               BLK_W     = 12,
    parameter int               SUBPG_SH  = 2,
    parameter logic [BLK_W-1:0] DENS_MASK = BLK_W'(12'h400),
    localparam int              SEC_W     = BLK_W + 7 + SUBPG_SH
) (
    input  logic [BLK_W-1:0] blk_num,
    input  logic             blk_hi,
    input  logic [7:0]       pg,
    output logic [SEC_W-1:0] sector
);
    logic [BLK_W-1:0] field;
    logic [SEC_W-1:0] page_sum;

    // Block field with optional density mask, then page/sector arithmetic.
    always_comb begin
        field    = blk_num | (blk_hi ? DENS_MASK : '0);
        page_sum = SEC_W'(pg[7:2]) + (SEC_W'(field) << 6);
        sector   = (page_sum << SUBPG_SH) + SEC_W'(pg[1:0]);
    end
endmodule

// File: rtl/boot_id_writer.sv
// Identification writer: on start, captures the identification bytes
// and emits them as consecutive boot-RAM word writes, one per cycle.
// Assumes start is never raised while busy.
module boot_id_writer
    import bootcmd_pkg::*;
#(
    parameter int N     = ID_WORDS,
    parameter int IDX_W = ID_IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [N-1:0][7:0]   src,
    output logic                we,
    output logic [IDX_W-1:0]    idx,
    output logic [15:0]         wdata,
    output logic                busy
);
    logic [N-1:0][7:0] held_q;
    logic [IDX_W-1:0]  cnt_q;
    logic              act_q;

    // Capture each source byte on start.
    for (genvar i = 0; i < N; i++) begin : g_hold
        always_ff @(posedge clk) begin
            if (!rst_n)     held_q[i] <= '0;
            else if (start) held_q[i] <= src[i];
        end
    end

    // Walk the word index while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            cnt_q <= '0;
        end else if (act_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == IDX_W'(N - 1)) act_q <= 1'b0;
        end
    end

    // Present the selected word, zero-extended.
    always_comb begin
        we    = act_q;
        idx   = cnt_q;
        wdata = {8'h00, held_q[cnt_q]};
        busy  = act_q;
    end
endmodule

// File: rtl/bootcmd_seq.sv
// Boot-window command sequencer. Decodes host writes into the boot
// windows: warm reset, identification store, and the two-write page
// load. The register file owns the block and page registers; this
// block only reads them and offers a page write-back strobe.
module bootcmd_seq
    import bootcmd_pkg::*;
#(
    parameter int               BLK_W     = 12,
    parameter int               SUBPG_SH  = 2,
    parameter logic [BLK_W-1:0] DENS_MASK = BLK_W'(12'h400),
    localparam int              SEC_W     = BLK_W + 7 + SUBPG_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [15:0]       bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic [BLK_W-1:0]  blk_num,
    input  logic              blk_hi,
    input  logic [7:0]        pg_reg,
    input  logic [7:0]        mfr_id,
    input  logic [7:0]        dev_id,
    input  logic [7:0]        wp_low,
    output logic              ld_req,
    output logic [SEC_W-1:0]  ld_sector,
    input  logic              ld_ack,
    output logic              pg_upd,
    output logic [7:0]        pg_upd_val,
    output logic              bram_we,
    output logic [1:0]        bram_widx,
    output logic [15:0]       bram_wdata,
    output logic              warm_rst,
    output logic              armed,
    output logic              unk_cmd,
    output logic              busy
);
    logic             in_win;
    logic [SEC_W-1:0] sec_now;
    logic             id_busy;
    logic             accept;
    logic             id_start;
    logic             armed_q, ld_req_q, pg_upd_q, warm_q, unk_q;
    logic [SEC_W-1:0] ld_sec_q;
    logic [7:0]       pg_hold_q, pg_val_q;

    boot_win_dec u_win (
        .addr   (bus_addr),
        .in_win (in_win)
    );

    boot_sector_calc #(
        .BLK_W     (BLK_W),
        .SUBPG_SH  (SUBPG_SH),
        .DENS_MASK (DENS_MASK)
    ) u_sec (
        .blk_num (blk_num),
        .blk_hi  (blk_hi),
        .pg      (pg_reg),
        .sector  (sec_now)
    );

    // Accept a boot write only when idle; start the ID store on 0x0090.
    always_comb begin
        accept   = bus_wr && in_win && !ld_req_q && !id_busy;
        id_start = accept && !armed_q && (bus_wdata == BC_IDENT);
    end

    boot_id_writer u_id (
        .clk   (clk),
        .rst_n (rst_n),
        .start (id_start),
        .src   ({wp_low, dev_id, mfr_id}),
        .we    (bram_we),
        .idx   (bram_widx),
        .wdata (bram_wdata),
        .busy  (id_busy)
    );

    // Command sequencing, load handshake and page write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            ld_req_q  <= 1'b0;
            ld_sec_q  <= '0;
            pg_hold_q <= '0;
            pg_upd_q  <= 1'b0;
            pg_val_q  <= '0;
            warm_q    <= 1'b0;
            unk_q     <= 1'b0;
        end else begin
            warm_q   <= 1'b0;
            pg_upd_q <= 1'b0;
            if (ld_req_q && ld_ack) begin
                ld_req_q <= 1'b0;
                pg_upd_q <= 1'b1;
                pg_val_q <= pg_hold_q + 8'd4;
            end
            if (accept) begin
                if (armed_q) begin
                    armed_q <= 1'b0;
                    if (bus_wdata == LOAD_CONFIRM) begin
                        ld_req_q  <= 1'b1;
                        ld_sec_q  <= sec_now;
                        pg_hold_q <= pg_reg;
                    end
                end else begin
                    case (bus_wdata)
                        BC_RESET: warm_q  <= 1'b1;
                        BC_LOAD:  armed_q <= 1'b1;
                        BC_IDENT: ;
                        default:  unk_q   <= 1'b1;
                    endcase
                end
            end
        end
    end

    // Drive the outputs from state.
    always_comb begin
        ld_req     = ld_req_q;
        ld_sector  = ld_sec_q;
        pg_upd     = pg_upd_q;
        pg_upd_val = pg_val_q;
        warm_rst   = warm_q;
        armed      = armed_q;
        unk_cmd    = unk_q;
        busy       = ld_req_q || id_busy;
    end
endmodule

// File: rtl/bootcmd_seq_chk.sv
// Property checker for the boot-window command sequencer, bound to the top.
module bootcmd_seq_chk #(
    parameter int SEC_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             warm_rst,
    input logic             armed,
    input logic             ld_req,
    input logic             ld_ack,
    input logic [SEC_W-1:0] ld_sector,
    input logic             pg_upd,
    input logic             unk_cmd,
    input logic             bram_we,
    input logic [1:0]       bram_widx
);
    // R2
    warm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> !warm_rst);
    // R6
    ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !ld_ack) |=> (ld_req && $stable(ld_sector)));
    // R6
    ld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_ack) |=> !ld_req);
    // R3
    armed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !ld_req);
    // R7
    pg_upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_upd |-> $past(ld_req && ld_ack));
    // R9
    unk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unk_cmd |=> unk_cmd);
    // R8
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bram_we && bram_widx != 2'd2) |=> (bram_we && bram_widx == $past(bram_widx) + 2'd1));
    // R8
    id_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bram_we |-> !ld_req);
endmodule

bind bootcmd_seq bootcmd_seq_chk #(.SEC_W(SEC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm_rst  (warm_rst),
    .armed     (armed),
    .ld_req    (ld_req),
    .ld_ack    (ld_ack),
    .ld_sector (ld_sector),
    .pg_upd    (pg_upd),
    .unk_cmd   (unk_cmd),
    .bram_we   (bram_we),
    .bram_widx (bram_widx)
);

// File: tb/bootcmd_seq_tb_top.sv
module bootcmd_seq_tb_top;
    localparam int BLK_W = 12;
    localparam int SEC_W = BLK_W + 7 + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [15:0]      bus_addr = '0;
    logic [15:0]      bus_wdata = '0;
    logic [BLK_W-1:0] blk_num = '0;
    logic             blk_hi = 1'b0;
    logic [7:0]       pg_reg = '0;
    logic [7:0]       mfr_id = 8'hEC;
    logic [7:0]       dev_id = 8'h36;
    logic [7:0]       wp_low = 8'h34;
    logic             ld_ack = 1'b0;
    logic             ld_req, pg_upd, bram_we, warm_rst, armed, unk_cmd, busy;
    logic [SEC_W-1:0] ld_sector;
    logic [7:0]       pg_upd_val;
    logic [1:0]       bram_widx;
    logic [15:0]      bram_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    bootcmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .blk_num(blk_num), .blk_hi(blk_hi),
        .pg_reg(pg_reg), .mfr_id(mfr_id), .dev_id(dev_id), .wp_low(wp_low),
        .ld_req(ld_req), .ld_sector(ld_sector), .ld_ack(ld_ack),
        .pg_upd(pg_upd), .pg_upd_val(pg_upd_val), .bram_we(bram_we),
        .bram_widx(bram_widx), .bram_wdata(bram_wdata), .warm_rst(warm_rst),
        .armed(armed), .unk_cmd(unk_cmd), .busy(busy)
    );

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(logic [15:0] a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    function automatic longint exp_sector(int blk, bit hi, int pg);
        int f;
        f = blk | (hi ? 'h400 : 0);
        return (pg % 4) + ((pg / 4) + f * 64) * 4;
    endfunction

    task automatic t_reset();
        check("R10 armed", armed, 0);
        check("R10 ld_req", ld_req, 0);
        check("R10 pg_upd", pg_upd, 0);
        check("R10 bram_we", bram_we, 0);
        check("R10 warm_rst", warm_rst, 0);
        check("R10 unk_cmd", unk_cmd, 0);
        check("R10 busy", busy, 0);
    endtask

    task automatic t_window();
        bwrite(16'h0200, 16'h00E0);
        check("R1 0x0200 ignored", armed, 0);
        bwrite(16'h8010, 16'h00F0);
        check("R1 0x8010 ignored", warm_rst, 0);
        bwrite(16'h01FF, 16'h00E0);
        check("R3 arm at 0x01FF", armed, 1);
        bwrite(16'h7FFF, 16'h0000);
        check("R1 outside keeps armed", armed, 1);
        check("R1 outside no load", ld_req, 0);
        bwrite(16'h800F, 16'h0001);
        check("R3 confirm clears armed", armed, 0);
        check("R4 nonzero cancels", ld_req, 0);
    endtask

    task automatic t_warm();
        bwrite(16'h8000, 16'h00F0);
        check("R2 pulse high", warm_rst, 1);
        idle(1);
        check("R2 pulse one cycle", warm_rst, 0);
        bwrite(16'h0000, 16'h00E0);
        bwrite(16'h8000, 16'h00F0);
        check("R3 second write not decoded", warm_rst, 0);
        check("R3 armed cleared", armed, 0);
        check("R3 no load", ld_req, 0);
    endtask

    task automatic t_load_race();
        blk_num = 12'd5; blk_hi = 1'b0; pg_reg = 8'hFE;
        bwrite(16'h0004, 16'h00E0);
        bwrite(16'h0004, 16'h0000);
        check("R4 load requested", ld_req, 1);
        check("R5 sector", ld_sector, exp_sector(5, 0, 'hFE));
        pg_reg = 8'h00;
        idle(2);
        check("R6 request held", ld_req, 1);
        bwrite(16'h0000, 16'h00E0);
        check("R6 write ignored while pending", armed, 0);
        check("R6 sector stable", ld_sector, exp_sector(5, 0, 'hFE));
        ld_ack = 1'b1;
        bus_wr = 1'b1; bus_addr = 16'h0000; bus_wdata = 16'h00E0;
        @(posedge clk); #1;
        ld_ack = 1'b0; bus_wr = 1'b0;
        check("R6 request dropped", ld_req, 0);
        check("R6 write in ack cycle ignored", armed, 0);
        check("R7 page update", pg_upd, 1);
        check("R7 page wraps", pg_upd_val, 8'h02);
        idle(1);
        check("R7 update one cycle", pg_upd, 0);
    endtask

    task automatic t_load_density();
        blk_num = 12'h003; blk_hi = 1'b1; pg_reg = 8'h11;
        bwrite(16'h800A, 16'h00E0);
        bwrite(16'h8001, 16'h0000);
        check("R5 density sector", ld_sector, exp_sector(3, 1, 'h11));
        ld_ack = 1'b1;
        @(posedge clk); #1;
        ld_ack = 1'b0;
        check("R7 page +4", pg_upd_val, 8'h15);
    endtask

    task automatic t_ident();
        bwrite(16'h0100, 16'h0090);
        check("R8 word0 we", bram_we, 1);
        check("R8 word0 idx", bram_widx, 0);
        check("R8 word0 data", bram_wdata, 16'h00EC);
        bwrite(16'h0100, 16'h00E0);
        check("R8 word1 idx", bram_widx, 1);
        check("R8 word1 data", bram_wdata, 16'h0036);
        check("R8 write during id ignored", armed, 0);
        idle(1);
        check("R8 word2 idx", bram_widx, 2);
        check("R8 word2 data", bram_wdata, 16'h0034);
        idle(1);
        check("R8 burst ends", bram_we, 0);
    endtask

    task automatic t_unknown();
        bwrite(16'h0010, 16'h1234);
        check("R9 flag set", unk_cmd, 1);
        check("R9 no arm", armed, 0);
        check("R9 no load", ld_req, 0);
        check("R9 no warm", warm_rst, 0);
        bwrite(16'h0010, 16'h00F0);
        idle(1);
        check("R9 flag sticky", unk_cmd, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_window();
        t_warm();
        t_load_race();
        t_load_density();
        t_ident();
        t_unknown();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule